// File: doc/BRIEF.md
# Fractional-Prescaled Microsecond Counter

This block keeps a free-running time base that steps once per microsecond while it is clocked straight from the system oscillator. The oscillator can run at any of several rates. A rational prescaler turns that rate into an average 1 MHz tick: each oscillator cycle adds a numerator to a small rate accumulator. When the accumulator reaches the denominator, the denominator is taken off and the counter steps. Both prescaler fields are stored minus one. With this scheme a rate such as 19.2 MHz gets an exact 1 MHz mean (numerator 5, denominator 96). Integer rates use a numerator of 1 (12, 13 and 26 MHz use denominators 12, 13 and 26).

Software sees two 32-bit registers through a plain strobe interface. The counter register is read-only. The prescaler register can be read and written. A read strobe returns its data one cycle later, and the counter value is caught in a single register stage, so a read never mixes two counter values. The interface carries single register accesses and no data stream, so it has no valid/ready handshake and no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `usec_timer`

## Requirements
- R1: After reset the counter reads 0, the prescaler register reads 0, and `bus_rvalid` is low.
- R2: A read strobe sampled on a clock edge raises `bus_rvalid` for exactly the next cycle. `bus_rdata` then holds the register value as it stood just before that edge. `bus_rvalid` is low in every other cycle.
- R3: The counter is decoded at byte address 0x10 and the prescaler at 0x14. Any other address reads 0, and writes to it change nothing.
- R4: Prescaler bits [7:0] hold the denominator minus one and bits [15:8] the numerator minus one. Bits [31:16] read as 0 whatever was written.
- R5: With numerator N no larger than denominator D, the counter advances by floor(k*N/D) over the k clock edges that follow a prescaler write. For example, 0x045F gives 50 steps in 960 cycles and 0x000B gives 100 steps in 1200 cycles.
- R6: When N is at least D (including the reset value 0), the counter advances on every clock edge.
- R7: A prescaler write clears the rate accumulator, and the counter does not advance on the edge of that write.
- R8: Writes to the counter address change neither the counter nor the accumulator phase.
- R9: The counter steps by exactly one per tick and wraps modulo 2^CNT_W. Its bits above CNT_W read as 0.
- R10: The rate accumulator always stays below the denominator, even when N exceeds D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read strobe |

## Verification
The bench sweeps every numerator from 1 to 4 against every denominator from 1 to 6, plus the four oscillator presets. It checks the exact step count over several window lengths, always counted from a fresh prescaler write. A design that failed to clear the accumulator on a write, or that compared with strict greater-than, would miss these counts by one. Ratios above one must run at full rate: a design that let the accumulator grow would show a rate that drifts. A design that stepped on the prescaler write edge, or that let a counter-address write disturb the count or the accumulator phase, breaks an exact count. A narrow-counter instance is run past its modulus to catch a wrong wrap or non-zero upper read bits.

// File: rtl/usec_pkg.sv
package usec_pkg;
  localparam int BUS_W   = 32;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] num_m1;
    logic [FIELD_W-1:0] den_m1;
  } rate_cfg_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_CFG
  } reg_sel_e;
endpackage

// File: rtl/usec_rate_accum.sv
module usec_rate_accum
  import usec_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] num_m1,
  input  logic [FW-1:0] den_m1,
  input  logic          clr,
  output logic          tick
);
  localparam int RW = FW + 1;
  localparam int SW = FW + 2;

  logic [RW-1:0] num1, den1, acc_q, acc_d;
  logic [SW-1:0] sum, rem;
  logic          over;

  always_comb begin
    num1 = {1'b0, num_m1} + RW'(1);
    den1 = {1'b0, den_m1} + RW'(1);
    sum  = {1'b0, acc_q} + {1'b0, num1};
    over = sum >= {1'b0, den1};
    rem  = sum - {1'b0, den1};
    if (!over)
      acc_d = sum[RW-1:0];
    else if (rem >= {1'b0, den1})
      acc_d = den1 - RW'(1);
    else
      acc_d = rem[RW-1:0];
    tick = over && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= acc_d;
  end

  // R10: residual never reaches the denominator
  a_r10_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < den1);
  // R7: configuration write restarts the phase and suppresses the step
  a_r7_clear_phase: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0);
  a_r7_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !tick);
  // R6: ratio at or above one gives a step every cycle
  a_r6_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && num1 >= den1) |-> tick);
endmodule

// File: rtl/usec_count.sv
module usec_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + CNT_W'(1);
  end

  // R9: single step per tick, modular wrap
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + CNT_W'(1));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/usec_regs.sv
module usec_regs
  import usec_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter int              CNT_W   = 32,
  parameter logic [ADDR_W-1:0] CNT_OFS = ADDR_W'(8'h10),
  parameter logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(8'h14)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output rate_cfg_t         cfg,
  output logic              cfg_clr,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid
);
  reg_sel_e        sel;
  logic [BUS_W-1:0] rd_mux;

  always_comb begin
    if (addr == CNT_OFS)      sel = SEL_CNT;
    else if (addr == CFG_OFS) sel = SEL_CFG;
    else                      sel = SEL_NONE;
    cfg_clr = wr && (sel == SEL_CFG);
    case (sel)
      SEL_CNT: rd_mux = BUS_W'(count);
      SEL_CFG: rd_mux = BUS_W'(cfg);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= '0;
    else if (cfg_clr) cfg <= wdata[$bits(rate_cfg_t)-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end

  // R2: response exactly one cycle after the strobe
  a_r2_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
  // R3: unmapped reads return zero
  a_r3_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> rdata == '0);
  // R4: configuration reads carry no upper bits
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_CFG) |=> rdata[BUS_W-1:$bits(rate_cfg_t)] == '0);
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                CNT_W   = 32,
  parameter logic [ADDR_W-1:0] CNT_OFS = ADDR_W'(8'h10),
  parameter logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(8'h14)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  rate_cfg_t        cfg;
  logic             cfg_clr;
  logic             tick;
  logic [CNT_W-1:0] count;

  usec_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CNT_OFS(CNT_OFS), .CFG_OFS(CFG_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .cfg(cfg), .cfg_clr(cfg_clr),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  usec_rate_accum #(.FW(FIELD_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .num_m1(cfg.num_m1), .den_m1(cfg.den_m1),
    .clr(cfg_clr), .tick(tick)
  );

  usec_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count)
  );
endmodule

// File: tb/usec_timer_test.sv
`timescale 1ns/1ps
module usec_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_w;
  logic        rvalid, rvalid_w;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usec_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .bus_rvalid(rvalid)
  );

  usec_timer #(.CNT_W(8)) uut_w (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_w), .bus_rvalid(rvalid_w)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entered and left just after a falling edge
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dw);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata; dw = rdata_w;
    if (!rvalid) begin
      checks++; errors++;
      $display("FAIL R2 actual=rvalid 0 expected=rvalid 1");
    end
  endtask

  function automatic logic [31:0] steps(input int num, input int den, input int k);
    if (num >= den) return k;
    return (k * num) / den;
  endfunction

  task automatic run_rate(input int num, input int den, input int n, input string req);
    logic [31:0] c0, c1, w0, w1;
    wr_reg(8'h14, 32'((num - 1) << 8 | (den - 1)));
    rd_reg(8'h10, c0, w0);
    repeat (n) @(negedge clk);
    rd_reg(8'h10, c1, w1);
    chk(req, c1 - c0, steps(num, den, n + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, dw, c0, c1, w0, w1;
    repeat (3) @(negedge clk);
    chk("R1 rvalid", {31'b0, rvalid}, 32'd0);
    rst_n = 1'b1;
    rd_reg(8'h10, d, dw);
    chk("R1 counter", d, 32'd0);
    rd_reg(8'h14, d, dw);
    chk("R1 config", d, 32'd0);
    @(negedge clk);
    chk("R2 rvalid drop", {31'b0, rvalid}, 32'd0);

    // R9 and R6: reset ratio runs at full rate, narrow copy wraps
    rd_reg(8'h10, c0, w0);
    repeat (300) @(negedge clk);
    rd_reg(8'h10, c1, w1);
    chk("R6 reset ratio", c1 - c0, 32'd301);
    chk("R9 wrap", w1, (w0 + 32'd301) & 32'hFF);
    chk("R9 upper zero", w1 & 32'hFFFF_FF00, 32'd0);

    // R4 field layout and masked upper half
    wr_reg(8'h14, 32'hABCD_045F);
    rd_reg(8'h14, d, dw);
    chk("R4 readback", d, 32'h0000_045F);

    // R3 unmapped address
    wr_reg(8'h18, 32'h0000_0000);
    rd_reg(8'h18, d, dw);
    chk("R3 unmapped read", d, 32'd0);
    rd_reg(8'h14, d, dw);
    chk("R3 unmapped write ignored", d, 32'h0000_045F);
    rd_reg(8'h00, d, dw);
    chk("R3 zero address", d, 32'd0);

    // R7: no step on the configuration write edge
    wr_reg(8'h14, 32'h0);
    rd_reg(8'h10, c0, w0);
    wr_reg(8'h14, 32'h0);
    rd_reg(8'h10, c1, w1);
    chk("R7 hold on write", c1 - c0, 32'd1);

    // R8: counter write leaves count and phase alone (ratio 1/3)
    wr_reg(8'h14, 32'h0000_0002);
    rd_reg(8'h10, c0, w0);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    rd_reg(8'h10, c1, w1);
    chk("R8 counter write ignored", c1 - c0, 32'd2);

    // R5: oscillator presets
    run_rate(1, 12, 1199, "R5 12MHz");
    run_rate(1, 13, 1299, "R5 13MHz");
    run_rate(5, 96, 959, "R5 19.2MHz");
    run_rate(5, 96, 95, "R5 19.2MHz partial");
    run_rate(1, 26, 2599, "R5 26MHz");

    // R5/R6/R10: sweep of small ratios and windows
    for (int nu = 1; nu <= 4; nu++)
      for (int de = 1; de <= 6; de++)
        for (int w = 0; w < 5; w++) begin
          int n;
          n = (w == 4) ? 11 : w * 2 - (w == 3 ? 1 : 0);
          run_rate(nu, de, n, (nu >= de) ? "R6 sweep" : "R5 sweep");
        end

    // R10: large ratio 256/1 still one step per cycle
    run_rate(256, 1, 40, "R10 saturated ratio");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule